// File: doc/BRIEF.md
# Speculative Epoch Sequencing Controller

This controller follows one speculative epoch through its life on a single processor context. A spawn request starts an epoch and carries its epoch number. The epoch then waits out a fixed fork latency, initialises and runs its speculative work. When the work completes, it waits until it holds the homefree token. It then asks the cache to commit, and once the cache reports that the commit is done, it hands the token to the next epoch.

Violations and exceptions are not acted on when they arrive. Each one is recorded in a pending flag. A recorded violation is acted on only when a poll strobe arrives after the work has completed. The controller then squashes and restarts the epoch, and it raises a squash output so that every logically later epoch can be squashed as well. An incoming squash from an earlier epoch has the same restart effect. A recorded exception is released only once the epoch holds the token.

The block also contains an epoch-number comparator. An epoch number is a thread identifier (upper bits) followed by a sequence number (lower bits). The comparator orders the current epoch against a second epoch number presented on an input.

The controller has eight named states:
- IDLE = 0. `spawn_req` moves it to SPAWNED.
- SPAWNED = 1. It moves to INIT when the fork timer expires.
- INIT = 2. It moves to WORK after one cycle.
- WORK = 3. `work_done` moves it to WAIT_HF.
- WAIT_HF = 4. A poll with a pending violation moves it to SQUASH. Holding the token with no violation moves it to COMMIT.
- COMMIT = 5. `commit_done` moves it to PASS_HF.
- PASS_HF = 6. It returns to IDLE after one cycle.
- SQUASH = 7. It moves to INIT after one cycle.

`squash_in` moves the controller to SQUASH from SPAWNED, INIT, WORK or WAIT_HF.

Top module: `epoch_seq_ctrl`

## Requirements
- R1: After reset `phase` reads 0 (IDLE), and `squash_req`, `commit_req`, `homefree_out` and `exc_fire` are all low.
- R2: `spawn_req` in IDLE captures `spawn_epoch` and enters SPAWNED (phase 1). The controller stays in SPAWNED for exactly SPAWN_LAT cycles (default 10), then spends one cycle in INIT (phase 2), then enters WORK (phase 3). `spawn_req` in any other phase is ignored: it changes neither the timing nor the stored epoch.
- R3: `work_done` in WORK moves the controller to WAIT_HF (phase 4).
- R4: A `violation` in SPAWNED, INIT, WORK or WAIT_HF is only recorded, and `squash_req` stays low. A `poll` in WAIT_HF while a violation is recorded moves the controller to SQUASH (phase 7) for one cycle with `squash_req` high, and then to INIT.
- R5: `squash_in` in SPAWNED, INIT, WORK or WAIT_HF moves the controller to SQUASH on the next edge.
- R6: The homefree token (`homefree_in`) is kept if it arrives in any phase other than IDLE. WAIT_HF moves to COMMIT (phase 5) only when the token is held and no violation is recorded. `commit_req` is high during the whole of COMMIT.
- R7: While in COMMIT, `violation` and `squash_in` are ignored, and the controller stays in COMMIT until `commit_done` arrives.
- R8: `commit_done` in COMMIT moves the controller to PASS_HF (phase 6). There `homefree_out` is high for exactly one cycle, and the controller then returns to IDLE.
- R9: An `exc_req` raised during SPAWNED, INIT, WORK or WAIT_HF is held back. `exc_fire` pulses for one cycle on the first cycle of COMMIT, and only while the token is held. A squash discards a held exception.
- R10: `order_res` is 2'b00 (unordered) when the thread identifier of `cmp_epoch` differs from that of the stored epoch.
- R11: When the thread identifiers match, let d be the stored sequence number minus the other sequence number, taken modulo 2^SEQ_W and read as a signed value. `order_res` is 2'b11 when d = 0, 2'b01 (stored epoch is earlier) when d < 0, and 2'b10 (stored epoch is later) when d > 0. This makes the order tolerant of wrap-around.
- R12: A squash clears the recorded violation. A poll after the restart, with no new violation, does not squash again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_req | input | 1 | Start a new epoch (accepted in IDLE only) |
| spawn_epoch | input | TID_W+SEQ_W | Epoch number of the spawned epoch |
| work_done | input | 1 | Speculative work has run to completion |
| violation | input | 1 | Dependence violation detected |
| squash_in | input | 1 | Squash request from an earlier epoch |
| poll | input | 1 | Violation poll strobe |
| exc_req | input | 1 | Exception raised during speculation |
| homefree_in | input | 1 | Homefree token from the previous epoch |
| commit_done | input | 1 | Cache reports that the commit is finished |
| cmp_epoch | input | TID_W+SEQ_W | Epoch number to order against the stored one |
| phase | output | 3 | Current state code |
| squash_req | output | 1 | Squash/restart request, also sent to later epochs |
| commit_req | output | 1 | Commit request to the cache |
| homefree_out | output | 1 | Homefree token passed to the next epoch |
| exc_fire | output | 1 | Deferred exception released |
| order_res | output | 2 | Ordering of the stored epoch against `cmp_epoch` |

## Verification
The assertions check the following on every cycle:
- `homefree_out` follows `commit_done` and lasts one cycle.
- `commit_req` and `exc_fire` appear only while the token is held.
- COMMIT is held until `commit_done`.
- Every squash leads into INIT.
- The fork timer stays within its range.

Only the bench's scenarios can show the rest:
- The exact length of SPAWNED.
- That `spawn_req` is ignored outside IDLE.
- That a violation waits for a poll, and that the squash clears it.
- That a squash discards a held exception.
- The signed wrap-around ordering, which is exercised by directed wrap points and by random epoch pairs.

// File: rtl/epoch_seq_pkg.sv
package epoch_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SPAWNED = 3'd1,
        PH_INIT    = 3'd2,
        PH_WORK    = 3'd3,
        PH_WAIT_HF = 3'd4,
        PH_COMMIT  = 3'd5,
        PH_PASS_HF = 3'd6,
        PH_SQUASH  = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        ORD_NONE   = 2'b00,
        ORD_BEFORE = 2'b01,
        ORD_AFTER  = 2'b10,
        ORD_SAME   = 2'b11
    } order_e;

endpackage

// File: rtl/epoch_order_cmp.sv
module epoch_order_cmp
    import epoch_seq_pkg::*;
#(
    parameter int TID_W = 4,
    parameter int SEQ_W = 8
) (
    input  logic [TID_W+SEQ_W-1:0] own_epoch,
    input  logic [TID_W+SEQ_W-1:0] other_epoch,
    output order_e                 result
);
    localparam int EW = TID_W + SEQ_W;

    logic             tid_match;
    logic [SEQ_W-1:0] seq_gap;

    assign tid_match = own_epoch[EW-1:SEQ_W] == other_epoch[EW-1:SEQ_W];
    assign seq_gap   = own_epoch[SEQ_W-1:0] - other_epoch[SEQ_W-1:0];

    // The sign bit of the modular difference decides the order.
    always_comb begin
        if (!tid_match)               result = ORD_NONE;
        else if (seq_gap == '0)       result = ORD_SAME;
        else if (seq_gap[SEQ_W-1])    result = ORD_BEFORE;
        else                          result = ORD_AFTER;
    end

endmodule

// File: rtl/spawn_timer.sv
module spawn_timer #(
    parameter int LAT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(LAT - 1);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LAT - 1)); // R2

endmodule

// File: rtl/epoch_seq_ctrl.sv
module epoch_seq_ctrl
    import epoch_seq_pkg::*;
#(
    parameter int TID_W     = 4,
    parameter int SEQ_W     = 8,
    parameter int SPAWN_LAT = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spawn_req,
    input  logic [TID_W+SEQ_W-1:0] spawn_epoch,
    input  logic                   work_done,
    input  logic                   violation,
    input  logic                   squash_in,
    input  logic                   poll,
    input  logic                   exc_req,
    input  logic                   homefree_in,
    input  logic                   commit_done,
    input  logic [TID_W+SEQ_W-1:0] cmp_epoch,
    output logic [2:0]             phase,
    output logic                   squash_req,
    output logic                   commit_req,
    output logic                   homefree_out,
    output logic                   exc_fire,
    output logic [1:0]             order_res
);
    localparam int EW = TID_W + SEQ_W;

    phase_e          state, state_n;
    logic [EW-1:0]   epoch_q;
    logic            viol_pend, exc_pend, hf_held;
    logic            spec_phase, viol_now, timer_start, timer_done;
    order_e          ord;

    assign spec_phase  = (state == PH_SPAWNED) || (state == PH_INIT) ||
                         (state == PH_WORK)    || (state == PH_WAIT_HF);
    assign viol_now    = viol_pend | violation;
    assign timer_start = (state == PH_IDLE) && spawn_req;

    spawn_timer #(.LAT(SPAWN_LAT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (timer_start),
        .expired (timer_done)
    );

    epoch_order_cmp #(.TID_W(TID_W), .SEQ_W(SEQ_W)) u_cmp (
        .own_epoch   (epoch_q),
        .other_epoch (cmp_epoch),
        .result      (ord)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            PH_IDLE:    if (spawn_req) state_n = PH_SPAWNED;
            PH_SPAWNED: if (squash_in) state_n = PH_SQUASH;
                        else if (timer_done) state_n = PH_INIT;
            PH_INIT:    if (squash_in) state_n = PH_SQUASH;
                        else state_n = PH_WORK;
            PH_WORK:    if (squash_in) state_n = PH_SQUASH;
                        else if (work_done) state_n = PH_WAIT_HF;
            PH_WAIT_HF: if (squash_in || (poll && viol_now)) state_n = PH_SQUASH;
                        else if (hf_held && !viol_now) state_n = PH_COMMIT;
            PH_COMMIT:  if (commit_done) state_n = PH_PASS_HF;
            PH_PASS_HF: state_n = PH_IDLE;
            PH_SQUASH:  state_n = PH_INIT;
        endcase
    end

    // Pending flags and captured epoch number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epoch_q   <= '0;
            viol_pend <= 1'b0;
            exc_pend  <= 1'b0;
            hf_held   <= 1'b0;
        end else begin
            if (timer_start) epoch_q <= spawn_epoch;
            if (state == PH_SQUASH) begin
                viol_pend <= 1'b0;
                exc_pend  <= 1'b0;
            end else if (spec_phase) begin
                if (violation) viol_pend <= 1'b1;
                if (exc_req)   exc_pend  <= 1'b1;
            end else if (exc_fire) begin
                exc_pend <= 1'b0;
            end
            if (state == PH_PASS_HF)                     hf_held <= 1'b0;
            else if (homefree_in && state != PH_IDLE)   hf_held <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        phase        = state;
        squash_req   = (state == PH_SQUASH);
        commit_req   = (state == PH_COMMIT);
        homefree_out = (state == PH_PASS_HF);
        exc_fire     = (state == PH_COMMIT) && exc_pend;
        order_res    = ord;
    end

    AST_HF_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        homefree_out |-> $past(commit_done)); // R8
    AST_HF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        homefree_out |=> !homefree_out); // R8
    AST_COMMIT_HAS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> hf_held); // R6
    AST_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !commit_done) |=> commit_req); // R7
    AST_SQUASH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        squash_req |=> (phase == PH_INIT)); // R4
    AST_EXC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        exc_fire |-> hf_held); // R9
    AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_fire |=> !exc_fire); // R9

endmodule

// File: tb/epoch_seq_ctrl_bench.sv
`timescale 1ns/1ps
module epoch_seq_ctrl_bench;
    localparam int TID_W = 4;
    localparam int SEQ_W = 8;
    localparam int EW    = TID_W + SEQ_W;
    localparam int LAT   = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          spawn_req, work_done, violation, squash_in, poll;
    logic          exc_req, homefree_in, commit_done;
    logic [EW-1:0] spawn_epoch, cmp_epoch;
    logic [2:0]    phase;
    logic          squash_req, commit_req, homefree_out, exc_fire;
    logic [1:0]    order_res;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    epoch_seq_ctrl #(.TID_W(TID_W), .SEQ_W(SEQ_W), .SPAWN_LAT(LAT)) u_epoch_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .spawn_req(spawn_req), .spawn_epoch(spawn_epoch),
        .work_done(work_done), .violation(violation), .squash_in(squash_in),
        .poll(poll), .exc_req(exc_req), .homefree_in(homefree_in),
        .commit_done(commit_done), .cmp_epoch(cmp_epoch), .phase(phase),
        .squash_req(squash_req), .commit_req(commit_req),
        .homefree_out(homefree_out), .exc_fire(exc_fire), .order_res(order_res)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int order_ref(input logic [EW-1:0] a, input logic [EW-1:0] b);
        logic [SEQ_W-1:0] d;
        if (a[EW-1:SEQ_W] != b[EW-1:SEQ_W]) return 0;
        d = a[SEQ_W-1:0] - b[SEQ_W-1:0];
        if (d == '0) return 3;
        if ($signed(d) < 0) return 1;
        return 2;
    endfunction

    task automatic spawn_to_work(input logic [EW-1:0] ep, input int ignore_at);
        spawn_req = 1'b1; spawn_epoch = ep;
        tick;
        spawn_req = 1'b0;
        check("R2", "phase after spawn", phase, 1);
        for (int i = 0; i < LAT - 1; i++) begin
            if (i == ignore_at) begin spawn_req = 1'b1; spawn_epoch = ~ep; end
            tick;
            spawn_req = 1'b0;
            check("R2", "phase in SPAWNED", phase, 1);
        end
        tick;
        check("R2", "phase INIT", phase, 2);
        tick;
        check("R2", "phase WORK", phase, 3);
    endtask

    task automatic finish_epoch;
        homefree_in = 1'b1; tick; homefree_in = 1'b0;
        work_done = 1'b1; tick; work_done = 1'b0;
        check("R3", "phase WAIT_HF", phase, 4);
        tick;
        check("R6", "phase COMMIT", phase, 5);
        check("R6", "commit_req", commit_req, 1);
        check("R9", "no exception", exc_fire, 0);
        commit_done = 1'b1; tick; commit_done = 1'b0;
        check("R8", "phase PASS_HF", phase, 6);
        check("R8", "homefree_out high", homefree_out, 1);
        tick;
        check("R8", "phase IDLE", phase, 0);
        check("R8", "homefree_out low", homefree_out, 0);
    endtask

    task automatic cmp_check(input logic [EW-1:0] own, input logic [EW-1:0] other);
        cmp_epoch = other;
        #1;
        if (own[EW-1:SEQ_W] != other[EW-1:SEQ_W])
            check("R10", "order unordered", order_res, order_ref(own, other));
        else
            check("R11", "order signed", order_res, order_ref(own, other));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [EW-1:0] ep;
        logic [31:0]   r;
        void'($urandom(32'd4242));
        rst_n = 1'b0; spawn_req = 0; work_done = 0; violation = 0; squash_in = 0;
        poll = 0; exc_req = 0; homefree_in = 0; commit_done = 0;
        spawn_epoch = '0; cmp_epoch = '0;
        repeat (3) tick;
        check("R1", "phase", phase, 0);
        check("R1", "squash_req", squash_req, 0);
        check("R1", "commit_req", commit_req, 0);
        check("R1", "homefree_out", homefree_out, 0);
        check("R1", "exc_fire", exc_fire, 0);
        rst_n = 1'b1;
        tick;

        // R2: spawn with an ignored second request mid-count
        ep = {4'h3, 8'h05};
        spawn_to_work(ep, 4);
        cmp_epoch = ep; #1;
        check("R2", "stored epoch kept", order_res, 3);
        cmp_check(ep, {4'h7, 8'h05});
        finish_epoch;

        // R4 / R12 / R7: deferred violation, squash, restart, commit immune
        spawn_to_work({4'h2, 8'h10}, -1);
        violation = 1'b1; tick; violation = 1'b0;
        check("R4", "no immediate squash", squash_req, 0);
        check("R4", "still WORK", phase, 3);
        work_done = 1'b1; tick; work_done = 1'b0;
        check("R3", "WAIT_HF", phase, 4);
        homefree_in = 1'b1; tick; homefree_in = 1'b0;
        check("R6", "no commit with violation", commit_req, 0);
        tick;
        check("R6", "waits for poll", phase, 4);
        poll = 1'b1; tick; poll = 1'b0;
        check("R4", "SQUASH phase", phase, 7);
        check("R4", "squash_req", squash_req, 1);
        tick;
        check("R4", "restart INIT", phase, 2);
        tick;
        check("R4", "WORK again", phase, 3);
        work_done = 1'b1; tick; work_done = 1'b0;
        check("R3", "WAIT_HF again", phase, 4);
        poll = 1'b1; tick; poll = 1'b0;
        check("R12", "commit after clean poll", phase, 5);
        check("R12", "no second squash", squash_req, 0);
        violation = 1'b1; squash_in = 1'b1; tick; violation = 1'b0; squash_in = 1'b0;
        check("R7", "COMMIT held", phase, 5);
        check("R7", "commit_req held", commit_req, 1);
        commit_done = 1'b1; tick; commit_done = 1'b0;
        check("R8", "PASS_HF", homefree_out, 1);
        tick;
        check("R8", "IDLE", phase, 0);

        // R9: exception held until homefree
        spawn_to_work({4'h1, 8'h20}, -1);
        exc_req = 1'b1; tick; exc_req = 1'b0;
        check("R9", "exc suppressed WORK", exc_fire, 0);
        work_done = 1'b1; tick; work_done = 1'b0;
        check("R9", "exc suppressed WAIT_HF", exc_fire, 0);
        tick;
        check("R9", "no token yet", phase, 4);
        homefree_in = 1'b1; tick; homefree_in = 1'b0;
        check("R9", "exc still held", exc_fire, 0);
        tick;
        check("R9", "COMMIT entered", phase, 5);
        check("R9", "exc released", exc_fire, 1);
        tick;
        check("R9", "exc one cycle", exc_fire, 0);
        commit_done = 1'b1; tick; commit_done = 1'b0;
        tick;
        check("R8", "IDLE after exc epoch", phase, 0);

        // R5: squash from earlier epoch, exception discarded
        spawn_req = 1'b1; spawn_epoch = {4'h4, 8'h33}; tick; spawn_req = 1'b0;
        repeat (3) tick;
        squash_in = 1'b1; tick; squash_in = 1'b0;
        check("R5", "squash in SPAWNED", phase, 7);
        check("R5", "squash_req", squash_req, 1);
        tick; tick;
        check("R5", "WORK after restart", phase, 3);
        exc_req = 1'b1; tick; exc_req = 1'b0;
        squash_in = 1'b1; tick; squash_in = 1'b0;
        check("R5", "squash in WORK", phase, 7);
        tick; tick;
        finish_epoch;

        // R11: wrap-around corners
        ep = {4'h5, 8'hFE};
        spawn_to_work(ep, -1);
        cmp_check(ep, {4'h5, 8'h01});
        cmp_check(ep, {4'h5, 8'hFD});
        cmp_check(ep, {4'h5, 8'h7E});
        cmp_check(ep, {4'h6, 8'hFE});
        finish_epoch;
        ep = {4'h5, 8'h02};
        spawn_to_work(ep, -1);
        cmp_check(ep, {4'h5, 8'hFF});
        finish_epoch;

        // Random epochs and comparisons
        for (int n = 0; n < 12; n++) begin
            r = $urandom; ep = r[EW-1:0];
            spawn_to_work(ep, -1);
            for (int k = 0; k < 16; k++) begin
                logic [EW-1:0] o;
                r = $urandom; o = r[EW-1:0];
                if (r[31]) o[EW-1:SEQ_W] = ep[EW-1:SEQ_W];
                cmp_check(ep, o);
            end
            finish_epoch;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule